// File: doc/BRIEF.md
# Master Clock Ratio Detector and Rate Normalizer

This block runs in the master clock domain. It finds out whether the master clock runs at 256 or 384 times the audio sample rate. It does this by timing the frame clock, which runs at the sample rate, in master clock cycles. It also counts bit clock edges in each frame, since the bit clock must run at 32 times the sample rate. The master clock is synchronous to the frame clock but may have any phase relative to it, so the block only measures the distance between rising frame edges and never uses an edge's position.

Once a ratio is confirmed, the block produces a clock enable that the downstream logic sees at the 256-times rate. In the 256 mode the enable is high on every cycle. In the 384 mode it is high on two cycles out of every three, in a fixed pattern. A clocks-valid status tells the rest of the chip whether all three clocks are present and consistent. An active-low power-down returns the block to its start state. All pins are plain control and status levels, with no handshake.

Top module: `mclk_ratio_norm`

## Requirements
- R1: The period between successive frame clock rising edges is measured in master clock cycles. A confirmed period of 256 sets `ratio_384` to 0, and a confirmed period of 384 sets it to 1.
- R2: A ratio is adopted, and `clocks_ok` goes to 1, only at a frame edge whose legal period equals the period measured at the frame edge just before it. The first frame edge after power-down only starts the measurement.
- R3: At a frame edge, `clocks_ok` drops to 0 and `ratio_384` keeps its value when either of these holds:
  - the period is neither 256 nor 384;
  - the number of bit clock rising edges in the frame is not 32.

  A bit edge that coincides with the closing frame edge counts toward the frame that is closing.
- R4: In the 384 mode, `clk_en` follows a period-3 pattern counted in master clock rising edges since power-down was released. With k being that count, `clk_en` is low when k mod 3 = 0 and high otherwise, so exactly 2 of every 3 cycles are enabled.
- R5: In the 256 mode, `clk_en` equals `clocks_ok` on every cycle.
- R6: `clk_en` is never high while `clocks_ok` is low.
- R7: If 385 master clock cycles pass with no frame rising edge, `clocks_ok` drops to 0.
- R8: While `pwr_dn_n` is low, `ratio_384`, `clocks_ok` and `clk_en` are 0 and all measurement state is cleared.
- R9: Detection does not depend on the phase of the frame clock relative to power-down release, or on the phase of the bit clock relative to the frame clock.
- R10: `frame_clk` and `bit_clk` pass through a two-stage synchronizer. An outcome decided at a frame edge appears on the outputs two master clock edges after the edge that first samples `frame_clk` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mclk | input | 1 | Master clock, the only clock of the block |
| pwr_dn_n | input | 1 | Active-low power-down, asynchronous assert |
| frame_clk | input | 1 | Frame (sample-rate) clock level |
| bit_clk | input | 1 | Bit clock level |
| ratio_384 | output | 1 | 1 when the confirmed ratio is 384, 0 for 256 |
| clk_en | output | 1 | Normalized 256-times clock enable |
| clocks_ok | output | 1 | All clocks present and consistent |

## Verification
Several properties are checked on every cycle by the assertions:
- `clk_en` never fires without `clocks_ok`;
- the 384 pattern never drops two cycles in a row, and never keeps three in a row;
- `clocks_ok` only rises on a measured frame edge;
- a timeout or a frame with the wrong bit count drops `clocks_ok` on the next cycle.

Other behaviours need the bench's scenarios:
- confirmation across two frames;
- the exact pattern phase counted from reset;
- switching between ratios;
- recovery after clocks stop;
- independence from frame and bit clock phase.

A cycle-by-cycle reference model covers these, together with directed checks.

// File: rtl/mclk_norm_pkg.sv
package mclk_norm_pkg;
  typedef enum logic {
    OSR_256 = 1'b0,
    OSR_384 = 1'b1
  } osr_mode_t;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], din};
  end

  assign rise = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/period_meter.sv
module period_meter #(
  parameter int RATIO_HI = 384,
  parameter int CW       = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_rise,
  input  logic          bit_rise,
  output logic          meas_stb,
  output logic [CW-1:0] meas_period,
  output logic [CW-1:0] meas_bits,
  output logic          timeout
);
  localparam logic [CW-1:0] CNT_CAP = CW'(RATIO_HI + 1);

  logic [CW-1:0] cyc_cnt;
  logic [CW-1:0] edge_cnt;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_cnt  <= '0;
      edge_cnt <= '0;
      armed    <= 1'b0;
    end else if (frame_rise) begin
      armed    <= 1'b1;
      cyc_cnt  <= CW'(1);
      edge_cnt <= '0;
    end else begin
      if (cyc_cnt != CNT_CAP) cyc_cnt <= cyc_cnt + CW'(1);
      if (bit_rise && edge_cnt != CNT_CAP) edge_cnt <= edge_cnt + CW'(1);
    end
  end

  assign meas_stb    = frame_rise & armed;
  assign meas_period = cyc_cnt;
  assign meas_bits   = edge_cnt + CW'(bit_rise);
  assign timeout     = ~frame_rise & (cyc_cnt == CNT_CAP);

  // R7: the period counter restarts at one after every frame edge
  assert_restart_after_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rise |=> (cyc_cnt == CW'(1)));
endmodule

// File: rtl/ratio_tracker.sv
module ratio_tracker
  import mclk_norm_pkg::*;
#(
  parameter int RATIO_LO = 256,
  parameter int RATIO_HI = 384,
  parameter int BITS     = 32,
  parameter int CW       = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          meas_stb,
  input  logic [CW-1:0] meas_period,
  input  logic [CW-1:0] meas_bits,
  input  logic          timeout,
  output osr_mode_t     mode,
  output logic          ok
);
  logic [CW-1:0] last_period;
  logic          legal;

  always_comb begin
    legal = ((meas_period == CW'(RATIO_LO)) || (meas_period == CW'(RATIO_HI)))
            && (meas_bits == CW'(BITS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_period <= '0;
      mode        <= OSR_256;
      ok          <= 1'b0;
    end else if (meas_stb) begin
      last_period <= legal ? meas_period : '0;
      if (legal && meas_period == last_period) begin
        ok   <= 1'b1;
        mode <= (meas_period == CW'(RATIO_HI)) ? OSR_384 : OSR_256;
      end else begin
        ok <= 1'b0;
      end
    end else if (timeout) begin
      ok <= 1'b0;
    end
  end

  // R2: valid can only rise on a measured frame edge
  assert_ok_rises_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok) |-> $past(meas_stb));
  // R1: the ratio only changes together with a confirmed frame
  assert_mode_change_confirmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> ok);
  // R3: a frame with the wrong bit count drops valid
  assert_bad_bits_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_stb && meas_bits != CW'(BITS)) |=> !ok);
  // R7: a missing frame edge drops valid
  assert_timeout_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !ok);
endmodule

// File: rtl/rate_gate.sv
module rate_gate #(
  parameter int RATIO_LO = 256,
  parameter int RATIO_HI = 384
) (
  input  logic clk,
  input  logic rst_n,
  output logic keep
);
  localparam int AW = $clog2(RATIO_HI) + 2;

  logic [AW-1:0] acc;
  logic [AW-1:0] sum;

  always_comb begin
    sum  = acc + AW'(RATIO_LO);
    keep = (sum >= AW'(RATIO_HI));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (keep) acc <= sum - AW'(RATIO_HI);
    else           acc <= sum;
  end

  // R4: no two dropped cycles in a row
  assert_no_double_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !keep |=> keep);
  // R4: never three kept cycles in a row
  assert_no_triple_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (keep && $past(keep)) |=> !keep);
endmodule

// File: rtl/mclk_ratio_norm.sv
module mclk_ratio_norm
  import mclk_norm_pkg::*;
#(
  parameter int RATIO_LO    = 256,
  parameter int RATIO_HI    = 384,
  parameter int BITS        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic mclk,
  input  logic pwr_dn_n,
  input  logic frame_clk,
  input  logic bit_clk,
  output logic ratio_384,
  output logic clk_en,
  output logic clocks_ok
);
  localparam int CW = $clog2(RATIO_HI + 2);
  localparam int NIN = 2;

  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] rises;
  logic           meas_stb;
  logic           timeout;
  logic [CW-1:0]  meas_period;
  logic [CW-1:0]  meas_bits;
  osr_mode_t      mode;
  logic           ok;
  logic           keep;

  assign raw_in = {bit_clk, frame_clk};

  for (genvar g = 0; g < NIN; g++) begin : g_sync
    edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (mclk),
      .rst_n(pwr_dn_n),
      .din  (raw_in[g]),
      .rise (rises[g])
    );
  end

  period_meter #(.RATIO_HI(RATIO_HI), .CW(CW)) u_meter (
    .clk        (mclk),
    .rst_n      (pwr_dn_n),
    .frame_rise (rises[0]),
    .bit_rise   (rises[1]),
    .meas_stb   (meas_stb),
    .meas_period(meas_period),
    .meas_bits  (meas_bits),
    .timeout    (timeout)
  );

  ratio_tracker #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI), .BITS(BITS), .CW(CW)) u_track (
    .clk        (mclk),
    .rst_n      (pwr_dn_n),
    .meas_stb   (meas_stb),
    .meas_period(meas_period),
    .meas_bits  (meas_bits),
    .timeout    (timeout),
    .mode       (mode),
    .ok         (ok)
  );

  rate_gate #(.RATIO_LO(RATIO_LO), .RATIO_HI(RATIO_HI)) u_gate (
    .clk  (mclk),
    .rst_n(pwr_dn_n),
    .keep (keep)
  );

  assign ratio_384 = (mode == OSR_384);
  assign clocks_ok = ok;
  assign clk_en    = ok & ((mode == OSR_256) | keep);

  // R6: enable never without valid clocks
  assert_en_needs_ok_R6: assert property (@(posedge mclk) disable iff (!pwr_dn_n)
    clk_en |-> clocks_ok);
  // R5: in the low ratio every valid cycle is enabled
  assert_low_ratio_full_rate_R5: assert property (@(posedge mclk) disable iff (!pwr_dn_n)
    (clocks_ok && !ratio_384) |-> clk_en);
endmodule

// File: tb/mclk_ratio_norm_test.sv
module mclk_ratio_norm_test;
  logic mclk = 1'b0;
  logic pwr_dn_n = 1'b0;
  logic frame_clk = 1'b0;
  logic bit_clk = 1'b0;
  logic ratio_384, clk_en, clocks_ok;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  mclk_ratio_norm uut (
    .mclk(mclk), .pwr_dn_n(pwr_dn_n), .frame_clk(frame_clk), .bit_clk(bit_clk),
    .ratio_384(ratio_384), .clk_en(clk_en), .clocks_ok(clocks_ok)
  );

  always #5 mclk = ~mclk;

  // stimulus generator for frame and bit clocks
  int gen_period = 256;
  int gen_bits = 32;
  int gen_boff = 0;
  int pos = 0;
  bit gen_on = 1;

  always @(negedge mclk) begin
    if (gen_on) begin
      int bp;
      pos = (pos + 1) % gen_period;
      bp = gen_period / gen_bits;
      frame_clk = (pos < gen_period / 2);
      bit_clk = (((pos + gen_boff) % bp) < bp / 2);
    end else begin
      frame_clk = 1'b0;
      bit_clk = 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on every rising edge
  int fq[$];
  int bq[$];
  bit m_armed, m_ok, m_mode;
  int m_cyc, m_bits, m_last, m_k;

  always @(posedge mclk) begin
    if (!pwr_dn_n) begin
      fq = {0, 0, 0, 0};
      bq = {0, 0, 0, 0};
      m_armed = 0; m_ok = 0; m_mode = 0;
      m_cyc = 0; m_bits = 0; m_last = 0; m_k = 0;
    end else begin
      bit fr, br;
      fq.push_back(int'(frame_clk));
      bq.push_back(int'(bit_clk));
      while (fq.size() > 6) void'(fq.pop_front());
      while (bq.size() > 6) void'(bq.pop_front());
      fr = (fq[fq.size()-3] == 1) && (fq[fq.size()-4] == 0);
      br = (bq[bq.size()-3] == 1) && (bq[bq.size()-4] == 0);
      m_k++;
      if (fr) begin
        if (m_armed) begin
          int p, b;
          bit good;
          p = m_cyc;
          b = m_bits + int'(br);
          good = (p == 256 || p == 384) && (b == 32);
          if (good && p == m_last) begin
            m_ok = 1;
            m_mode = (p == 384);
          end else m_ok = 0;
          m_last = good ? p : 0;
        end
        m_armed = 1;
        m_cyc = 1;
        m_bits = 0;
      end else begin
        if (m_cyc == 385) m_ok = 0;
        else m_cyc++;
        if (br && m_bits < 385) m_bits++;
      end
    end
    #2;
    if (!done) begin
      check("R1 ratio_384", int'(ratio_384), int'(m_mode));
      check("R2 R10 clocks_ok", int'(clocks_ok), int'(m_ok));
      check("R4 R5 R6 clk_en", int'(clk_en),
            int'(m_ok && (!m_mode || (m_k % 3) != 0)));
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge mclk);
  endtask

  task automatic count_en(input int n, output int cnt);
    cnt = 0;
    repeat (n) begin
      @(negedge mclk);
      cnt += int'(clk_en);
    end
  endtask

  initial begin
    int cnt;
    wait_cycles(5);
    check("R8 reset ratio_384", int'(ratio_384), 0);
    check("R8 reset clocks_ok", int'(clocks_ok), 0);
    check("R8 reset clk_en", int'(clk_en), 0);
    pwr_dn_n = 1'b1;
    // low ratio lock
    wait_cycles(2 * 256 + 20);
    check("R2 not yet confirmed", int'(clocks_ok), 0);
    wait_cycles(3 * 256);
    check("R2 low ratio valid", int'(clocks_ok), 1);
    check("R1 low ratio flag", int'(ratio_384), 0);
    count_en(100, cnt);
    check("R5 full rate enable count", cnt, 100);
    // switch to high ratio
    gen_period = 384;
    wait_cycles(5 * 384);
    check("R1 high ratio flag", int'(ratio_384), 1);
    check("R2 high ratio valid", int'(clocks_ok), 1);
    count_en(300, cnt);
    check("R4 two of three enabled", cnt, 200);
    // bad bit clock rate
    gen_bits = 16;
    wait_cycles(2 * 384 + 10);
    check("R3 bad bit count drops valid", int'(clocks_ok), 0);
    check("R3 flag held", int'(ratio_384), 1);
    count_en(50, cnt);
    check("R6 no enable while invalid", cnt, 0);
    gen_bits = 32;
    wait_cycles(4 * 384);
    check("R3 recovery", int'(clocks_ok), 1);
    // illegal period
    gen_period = 320;
    wait_cycles(2 * 320 + 10);
    check("R3 illegal period drops valid", int'(clocks_ok), 0);
    check("R3 flag held after illegal", int'(ratio_384), 1);
    gen_period = 384;
    wait_cycles(5 * 384);
    check("R3 relock", int'(clocks_ok), 1);
    // clocks stop
    gen_on = 0;
    wait_cycles(450);
    check("R7 missing frame drops valid", int'(clocks_ok), 0);
    // power down while running
    gen_on = 1;
    wait_cycles(4 * 384);
    pwr_dn_n = 1'b0;
    wait_cycles(3);
    check("R8 pd clears ratio", int'(ratio_384), 0);
    check("R8 pd clears valid", int'(clocks_ok), 0);
    check("R8 pd clears enable", int'(clk_en), 0);
    // restart at a different frame and bit phase
    gen_period = 256;
    pos = 100;
    gen_boff = 3;
    wait_cycles(2);
    pwr_dn_n = 1'b1;
    wait_cycles(5 * 256);
    check("R9 lock with other phase", int'(clocks_ok), 1);
    check("R9 low ratio with other phase", int'(ratio_384), 0);
    gen_period = 384;
    gen_boff = 7;
    wait_cycles(5 * 384);
    check("R9 high ratio with other phase", int'(ratio_384), 1);
    done = 1;
    wait_cycles(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule